// File: doc/BRIEF.md
# Latched Serial-In Open-Drain Driver

This block takes a serial bit stream, moves it through a chain of storage stages on each rising clock edge, and copies the chain into a level-sensitive holding latch whenever a load strobe is high. The held word drives a row of open-drain style outputs. Each output pulls low when its held bit is 1 and the output gate is on. Otherwise it floats. The output gate acts on the pads only. It never changes the chain or the held word.

Two cascade taps carry the chain's last stage to a downstream copy of the block. One tap changes on the rising edge, for fast clock edges. The other changes half a cycle later, on the falling edge, for systems whose clock rises slowly. Through either tap, two chained copies behave as a single chain of twice the length.

Top module: `od_shift_latch`

## Requirements
- R1: On each rising clock edge with reset low, stage 0 takes `sdi`, and stage k takes the previous value of stage k-1 for k = 1 to STAGES-1.
- R2: While `le` is 1, the held word equals the chain, with held bit k equal to stage k. While `le` is 0, the held word keeps its value, whatever `sdi` and the clock do.
- R3: `drive_on[k]` equals held bit k when `oe` is 1. All bits of `drive_on` are 0 when `oe` is 0.
- R4: Changing `oe` leaves the chain and the held word unchanged. Once `oe` returns to 1, the outputs show the contents as if `oe` had never been 0.
- R5: `cas_rise` equals stage STAGES-1 and changes only on rising clock edges.
- R6: `cas_fall` takes the value of `cas_rise` on each falling clock edge. It therefore lags `cas_rise` by half a cycle.
- R7: While `rst` is 1, the held word clears at once and is 0 after the next edge. The chain and `cas_rise` clear on the next rising edge, and `cas_fall` clears on the next falling edge.
- R8: A second instance whose `sdi` is fed from `cas_rise` behaves as stages STAGES to 2*STAGES-1 of a single chain of 2*STAGES stages.
- R9: A second instance whose `sdi` is fed from `cas_fall` behaves the same way as in R8.
- R10: `pad[k]` is 0 when `drive_on[k]` is 1, and high impedance when `drive_on[k]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Shifts on the rising edge; the falling edge re-times `cas_fall`. |
| rst | input | 1 | Active-high clear. |
| sdi | input | 1 | Serial data into stage 0. |
| le | input | 1 | Load strobe. The latch is transparent while this is high. |
| oe | input | 1 | Output gate for the pads. |
| drive_on | output | STAGES | Pull-low enable for each pad. |
| pad | output | STAGES | Open-drain pad value: 0 or z. |
| cas_rise | output | 1 | Cascade tap updated on the rising edge. |
| cas_fall | output | 1 | Cascade tap updated on the falling edge. |

## Verification
The hardest case is showing that the held word and the chain stay untouched while `oe` is 0, because nothing is visible at the pads during that time. The stimulus shifts a known pattern and closes the latch with `oe` low. It then raises `oe` first with `le` still low, to expose the held word, and then raises `le` to expose the chain. The dual-edge cascade is covered by three instances running side by side. Their outputs are compared on every rising and falling edge against a single 24-stage model.

// File: rtl/od_sr_pkg.sv
package od_sr_pkg;
  localparam int unsigned DEF_STAGES = 12;

  typedef enum logic {PAD_FLOAT = 1'b0, PAD_PULL = 1'b1} pad_mode_e;
endpackage

// File: rtl/sr_stage_chain.sv
module sr_stage_chain #(
  parameter int unsigned STAGES = od_sr_pkg::DEF_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din,
  output logic [STAGES-1:0] stage_q
);
  localparam int unsigned LAST = STAGES - 1;

  always_ff @(posedge clk) begin
    if (rst) stage_q <= '0;
    else     stage_q <= {stage_q[LAST-1:0], din};
  end
endmodule

// File: rtl/sr_store_latch.sv
module sr_store_latch #(
  parameter int unsigned STAGES = od_sr_pkg::DEF_STAGES
) (
  input  logic              rst,
  input  logic              le,
  input  logic [STAGES-1:0] d,
  output logic [STAGES-1:0] q
);
  always_latch begin
    if (rst)     q <= '0;
    else if (le) q <= d;
  end
endmodule

// File: rtl/sr_fall_retime.sv
module sr_fall_retime (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  always_ff @(negedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= d;
  end
endmodule

// File: rtl/od_pad_cell.sv
module od_pad_cell (
  input  logic held,
  input  logic oe,
  output logic drv,
  output wire  pad
);
  import od_sr_pkg::*;
  pad_mode_e mode;

  always_comb mode = (held && oe) ? PAD_PULL : PAD_FLOAT;
  assign drv = (mode == PAD_PULL);
  assign pad = drv ? 1'b0 : 1'bz;
endmodule

// File: rtl/od_shift_latch.sv
module od_shift_latch #(
  parameter int unsigned STAGES = od_sr_pkg::DEF_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sdi,
  input  logic              le,
  input  logic              oe,
  output logic [STAGES-1:0] drive_on,
  output wire  [STAGES-1:0] pad,
  output logic              cas_rise,
  output logic              cas_fall
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] held_q;

  sr_stage_chain #(.STAGES(STAGES)) u_chain (
    .clk     (clk),
    .rst     (rst),
    .din     (sdi),
    .stage_q (stage_q)
  );

  sr_store_latch #(.STAGES(STAGES)) u_store (
    .rst (rst),
    .le  (le),
    .d   (stage_q),
    .q   (held_q)
  );

  assign cas_rise = stage_q[LAST];

  sr_fall_retime u_retime (
    .clk (clk),
    .rst (rst),
    .d   (cas_rise),
    .q   (cas_fall)
  );

  for (genvar k = 0; k < STAGES; k++) begin : g_pad
    od_pad_cell u_cell (
      .held (held_q[k]),
      .oe   (oe),
      .drv  (drive_on[k]),
      .pad  (pad[k])
    );
  end
endmodule

// File: rtl/od_shift_latch_chk.sv
module od_shift_latch_chk #(
  parameter int unsigned STAGES = od_sr_pkg::DEF_STAGES
) (
  input logic              clk,
  input logic              rst,
  input logic              sdi,
  input logic              le,
  input logic              oe,
  input logic [STAGES-1:0] drive_on,
  input logic              cas_rise,
  input logic              cas_fall,
  input logic [STAGES-1:0] stage_q
);
  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (stage_q[0] == $past(sdi))); // R1
  AST_HOLD_CLOSED: assert property (@(posedge clk) disable iff (rst)
    (!le && $past(!le) && oe && $past(oe) && !$past(rst)) |-> $stable(drive_on)); // R2
  AST_GATE_OFF: assert property (@(posedge clk) disable iff (rst)
    !oe |-> (drive_on == '0)); // R3
  AST_TAP_RISE: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (cas_rise == $past(stage_q[STAGES-2]))); // R5
  AST_TAP_FALL: assert property (@(posedge clk) disable iff (rst)
    cas_fall == cas_rise); // R6
  AST_CLEAR: assert property (@(posedge clk)
    rst |=> (cas_rise == 1'b0 && drive_on == '0)); // R7
endmodule

bind od_shift_latch od_shift_latch_chk #(.STAGES(STAGES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sdi      (sdi),
  .le       (le),
  .oe       (oe),
  .drive_on (drive_on),
  .cas_rise (cas_rise),
  .cas_fall (cas_fall),
  .stage_q  (stage_q)
);

// File: tb/tb_od_shift_latch.sv
module tb_od_shift_latch;
  localparam int N = 12;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = CLK_PERIOD / 2;

  logic clk = 1'b0;
  logic rst, sdi, le, oe;
  logic [N-1:0] drv_a, drv_b, drv_c;
  wire  [N-1:0] pad_a, pad_b, pad_c;
  logic cr_a, cf_a, cr_b, cf_b, cr_c, cf_c;

  od_shift_latch #(.STAGES(N)) dut (
    .clk(clk), .rst(rst), .sdi(sdi), .le(le), .oe(oe),
    .drive_on(drv_a), .pad(pad_a), .cas_rise(cr_a), .cas_fall(cf_a));
  od_shift_latch #(.STAGES(N)) dut_b (
    .clk(clk), .rst(rst), .sdi(cr_a), .le(le), .oe(oe),
    .drive_on(drv_b), .pad(pad_b), .cas_rise(cr_b), .cas_fall(cf_b));
  od_shift_latch #(.STAGES(N)) dut_c (
    .clk(clk), .rst(rst), .sdi(cf_a), .le(le), .oe(oe),
    .drive_on(drv_c), .pad(pad_c), .cas_rise(cr_c), .cas_fall(cf_c));

  always #(HALF) clk = ~clk;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  string cur = "R7";

  logic [2*N-1:0] m_sh = '0;
  logic [2*N-1:0] m_st = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h @%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic d, input logic l, input logic o, input logic r);
    logic [N-1:0] ea, eb;
    sdi = d; le = l; oe = o; rst = r;
    @(posedge clk); #1;
    if (r) begin m_sh = '0; m_st = '0; end
    else begin
      m_sh = {m_sh[2*N-2:0], d};
      if (l) m_st = m_sh;
    end
    ea = m_st[N-1:0] & {N{o}};
    eb = m_st[2*N-1:N] & {N{o}};
    chk(cur, 32'(drv_a), 32'(ea));
    chk("R8", 32'(drv_b), 32'(eb));
    chk("R9", 32'(drv_c), 32'(eb));
    chk("R5", 32'(cr_a), 32'(m_sh[N-1]));
    chk("R8", 32'(cr_b), 32'(m_sh[2*N-1]));
    chk("R9", 32'(cr_c), 32'(m_sh[2*N-1]));
    for (int k = 0; k < N; k++)
      if (ea[k]) chk("R10", 32'(pad_a[k] === 1'b0), 32'd1);
    @(negedge clk); #1;
    chk("R6", 32'(cf_a), 32'(r ? 1'b0 : m_sh[N-1]));
    chk("R9", 32'(cf_c), 32'(r ? 1'b0 : m_sh[2*N-1]));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf = 16'hACE1;
    cur = "R7";
    cyc(1'b1, 1'b1, 1'b1, 1'b1);
    cyc(1'b1, 1'b1, 1'b1, 1'b1);
    // R1: fill both chains with a pseudo-random stream, latch open
    cur = "R1";
    for (int i = 0; i < 40; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cyc(lf[0], 1'b1, 1'b1, 1'b0);
    end
    // R1: all-ones then alternating patterns
    for (int i = 0; i < 26; i++) cyc(1'b1, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 26; i++) cyc(1'(i % 2), 1'b1, 1'b1, 1'b0);
    // R2: latch closed, chain keeps moving
    cur = "R2";
    for (int i = 0; i < 15; i++) cyc(1'(i % 3 == 0), 1'b0, 1'b1, 1'b0);
    cyc(1'b0, 1'b1, 1'b1, 1'b0);
    // R3: gate off while shifting and loading
    cur = "R3";
    for (int i = 0; i < 10; i++) cyc(1'b1, 1'(i < 5), 1'b0, 1'b0);
    // R4: restore gate with latch closed, then open latch
    cur = "R4";
    cyc(1'b0, 1'b0, 1'b1, 1'b0);
    cyc(1'b1, 1'b0, 1'b1, 1'b0);
    cyc(1'b0, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 6; i++) cyc(1'b1, 1'b1, 1'(i % 2), 1'b0);
    // R7: mid-run clear, then refill
    cur = "R7";
    cyc(1'b1, 1'b0, 1'b1, 1'b1);
    cyc(1'b1, 1'b1, 1'b1, 1'b0);
    cur = "R1";
    for (int i = 0; i < 30; i++) cyc(1'(i % 5 < 2), 1'b1, 1'b1, 1'b0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule